// File: doc/BRIEF.md
# DMA Burst Trigger

This block decides, cycle by cycle, whether the transmit or the receive DMA engine may ask the bus master for a data burst. It also says how many beats that burst carries.

The transmit side looks at free space in its FIFO and at the bytes still to be fetched for the current frame. The receive side looks at the fill level of its FIFO and at whether an end of frame has already landed there. Each side may launch either a full programmed burst or a shorter tail burst that closes a frame. When both sides qualify in the same cycle, a round-robin choice picks one of them.

The block also sizes descriptor reads. A descriptor is 16 bytes long and is read in one burst, limited by both the programmed burst limit and the bus width.

Top module: `dma_burst_trigger`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `req_valid` is 0.
- R2: The transmit side qualifies for a full burst when `tx_left` and `tx_free` are both at least `pbl`×(BUS_W/8) bytes. A full burst carries `pbl` beats.
- R3: The transmit side qualifies for a tail burst when 0 < `tx_left` < one burst and `tx_free` ≥ `tx_left`. A tail burst carries ceil(`tx_left`/(BUS_W/8)) beats.
- R4: With `tx_left` equal to 0, the transmit side never qualifies.
- R5: The receive side qualifies for a full burst when `rx_fill` ≥ one burst. A full burst carries `pbl` beats.
- R6: When `rx_eof` is 1 and 0 < `rx_fill` < one burst, the receive side qualifies and the burst carries ceil(`rx_fill`/(BUS_W/8)) beats. When `rx_eof` is 0, a partial fill never qualifies.
- R7: An engine whose run input (`tx_run` or `rx_run`) is 0 never receives a request, whatever its FIFO state.
- R8: When both sides qualify, the grant goes to the side that was not granted most recently. After reset, transmit goes first. `req_is_rx` is 1 for receive and 0 for transmit.
- R9: The request outputs are registered. `req_valid`, `req_is_rx`, `req_addr` (the granted engine's address) and `req_beats` reflect the inputs seen at the previous rising clock edge.
- R10: `desc_beats` is combinational and equals min(`pbl`, 128/BUS_W).
- R11: When `pbl` is 0, no data request is made.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pbl | input | PBL_W | Programmed burst limit in beats |
| tx_run | input | 1 | Transmit engine running |
| tx_free | input | CNT_W | Free bytes in transmit FIFO |
| tx_left | input | CNT_W | Bytes left to fetch for current transmit frame |
| tx_addr | input | ADDR_W | Next transmit buffer address |
| rx_run | input | 1 | Receive engine running |
| rx_fill | input | CNT_W | Bytes held in receive FIFO |
| rx_eof | input | 1 | End of frame present in receive FIFO |
| rx_addr | input | ADDR_W | Next receive buffer address |
| req_valid | output | 1 | Burst request strobe |
| req_is_rx | output | 1 | 1 = receive engine, 0 = transmit engine |
| req_addr | output | ADDR_W | Start address of the burst |
| req_beats | output | PBL_W | Beats in the burst |
| desc_beats | output | PBL_W | Beats for a 16-byte descriptor read |

## Verification
The assertions check the following on every cycle:
- a granted engine was running and qualified on the cycle before;
- a request never exceeds the burst limit and is never empty;
- back-to-back contention alternates between the two sides;
- descriptor sizing stays within both of its limits.

The exact tail beat counts, the threshold edges one byte either side of a burst, and the effect of `rx_eof` on a partial fill can only be shown by the bench's scenarios. The same holds for address routing, all of which the reference model compares every clock.

// File: rtl/dbt_pkg.sv
package dbt_pkg;
  // Beats needed to move a byte count on a bus with lane_b bytes per beat.
  function automatic int unsigned beats_for(input int unsigned nbytes, input int unsigned lane_b);
    return (nbytes + lane_b - 1) / lane_b;
  endfunction

  function automatic int unsigned min_u(input int unsigned a, input int unsigned b);
    return (a < b) ? a : b;
  endfunction
endpackage

// File: rtl/dbt_tx_gate.sv
module dbt_tx_gate #(
  parameter int PBL_W  = 6,
  parameter int CNT_W  = 16,
  parameter int LANE_B = 4
) (
  input  logic             run,
  input  logic [PBL_W-1:0] pbl,
  input  logic [CNT_W-1:0] free_b,
  input  logic [CNT_W-1:0] left_b,
  output logic             elig,
  output logic [PBL_W-1:0] beats
);
  import dbt_pkg::*;

  int unsigned burst_b, free_u, left_u;
  logic        full_ok, tail_ok;

  always_comb begin
    burst_b = 32'(pbl) * 32'(LANE_B);
    free_u  = 32'(free_b);
    left_u  = 32'(left_b);
    full_ok = (left_u >= burst_b) && (free_u >= burst_b);
    tail_ok = (left_u != 0) && (left_u < burst_b) && (free_u >= left_u);
    elig    = run && (burst_b != 0) && (full_ok || tail_ok);
    beats   = full_ok ? pbl : PBL_W'(beats_for(left_u, LANE_B));
  end
endmodule

// File: rtl/dbt_rx_gate.sv
module dbt_rx_gate #(
  parameter int PBL_W  = 6,
  parameter int CNT_W  = 16,
  parameter int LANE_B = 4
) (
  input  logic             run,
  input  logic [PBL_W-1:0] pbl,
  input  logic [CNT_W-1:0] fill_b,
  input  logic             eof_in,
  output logic             elig,
  output logic [PBL_W-1:0] beats
);
  import dbt_pkg::*;

  int unsigned burst_b, fill_u;
  logic        full_ok, tail_ok;

  always_comb begin
    burst_b = 32'(pbl) * 32'(LANE_B);
    fill_u  = 32'(fill_b);
    full_ok = fill_u >= burst_b;
    tail_ok = eof_in && (fill_u != 0) && (fill_u < burst_b);
    elig    = run && (burst_b != 0) && (full_ok || tail_ok);
    beats   = full_ok ? pbl : PBL_W'(beats_for(fill_u, LANE_B));
  end
endmodule

// File: rtl/dbt_rr_arb.sv
module dbt_rr_arb (
  input  logic clk,
  input  logic rst_n,
  input  logic want_tx,
  input  logic want_rx,
  output logic pick_tx,
  output logic pick_rx
);
  logic favour_rx;

  always_comb begin
    pick_rx = want_rx && (!want_tx || favour_rx);
    pick_tx = want_tx && !pick_rx;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      favour_rx <= 1'b0;
    else if (pick_tx)
      favour_rx <= 1'b1;
    else if (pick_rx)
      favour_rx <= 1'b0;
  end
endmodule

// File: rtl/dma_burst_trigger.sv
module dma_burst_trigger #(
  parameter int BUS_W  = 32,
  parameter int PBL_W  = 6,
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PBL_W-1:0]  pbl,
  input  logic              tx_run,
  input  logic [CNT_W-1:0]  tx_free,
  input  logic [CNT_W-1:0]  tx_left,
  input  logic [ADDR_W-1:0] tx_addr,
  input  logic              rx_run,
  input  logic [CNT_W-1:0]  rx_fill,
  input  logic              rx_eof,
  input  logic [ADDR_W-1:0] rx_addr,
  output logic              req_valid,
  output logic              req_is_rx,
  output logic [ADDR_W-1:0] req_addr,
  output logic [PBL_W-1:0]  req_beats,
  output logic [PBL_W-1:0]  desc_beats
);
  localparam int LANE_B   = BUS_W / 8;
  localparam int DESC_MAX = 128 / BUS_W;

  logic             tx_elig, rx_elig, gnt_tx, gnt_rx;
  logic [PBL_W-1:0] tx_beats, rx_beats;

  dbt_tx_gate #(.PBL_W(PBL_W), .CNT_W(CNT_W), .LANE_B(LANE_B)) u_tx (
    .run(tx_run), .pbl(pbl), .free_b(tx_free), .left_b(tx_left),
    .elig(tx_elig), .beats(tx_beats)
  );

  dbt_rx_gate #(.PBL_W(PBL_W), .CNT_W(CNT_W), .LANE_B(LANE_B)) u_rx (
    .run(rx_run), .pbl(pbl), .fill_b(rx_fill), .eof_in(rx_eof),
    .elig(rx_elig), .beats(rx_beats)
  );

  dbt_rr_arb u_arb (
    .clk(clk), .rst_n(rst_n), .want_tx(tx_elig), .want_rx(rx_elig),
    .pick_tx(gnt_tx), .pick_rx(gnt_rx)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_valid <= 1'b0;
      req_is_rx <= 1'b0;
      req_addr  <= '0;
      req_beats <= '0;
    end else begin
      req_valid <= gnt_tx || gnt_rx;
      req_is_rx <= gnt_rx;
      req_addr  <= gnt_rx ? rx_addr : tx_addr;
      req_beats <= gnt_rx ? rx_beats : (gnt_tx ? tx_beats : '0);
    end
  end

  always_comb begin
    if (32'(pbl) < 32'(DESC_MAX))
      desc_beats = pbl;
    else
      desc_beats = PBL_W'(DESC_MAX);
  end
endmodule

// File: rtl/dma_burst_trigger_chk.sv
module dma_burst_trigger_chk #(
  parameter int BUS_W = 32,
  parameter int PBL_W = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic [PBL_W-1:0] pbl,
  input logic             tx_run,
  input logic             rx_run,
  input logic             req_valid,
  input logic             req_is_rx,
  input logic [PBL_W-1:0] req_beats,
  input logic [PBL_W-1:0] desc_beats,
  input logic             tx_elig,
  input logic             rx_elig
);
  localparam int DESC_MAX = 128 / BUS_W;

  AST_TX_STOPPED_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_is_rx) |-> $past(tx_run && tx_elig)); // R7
  AST_RX_STOPPED_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_is_rx) |-> $past(rx_run && rx_elig)); // R7
  AST_BEATS_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (req_beats != 0 && req_beats <= $past(pbl))); // R2
  AST_ZERO_PBL_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    $past(pbl == 0) |-> !req_valid); // R11
  AST_RR_ALTERNATE: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && $past(req_valid) && $past(tx_elig && rx_elig)) |-> (req_is_rx != $past(req_is_rx))); // R8

  always_comb begin
    if (rst_n) begin
      AST_DESC_BOUNDED: assert (32'(desc_beats) <= 32'(DESC_MAX) && desc_beats <= pbl); // R10
    end
  end
endmodule

bind dma_burst_trigger dma_burst_trigger_chk #(.BUS_W(BUS_W), .PBL_W(PBL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .pbl(pbl), .tx_run(tx_run), .rx_run(rx_run),
  .req_valid(req_valid), .req_is_rx(req_is_rx), .req_beats(req_beats),
  .desc_beats(desc_beats), .tx_elig(tx_elig), .rx_elig(rx_elig)
);

// File: tb/test_dma_burst_trigger.sv
module test_dma_burst_trigger;
  localparam int BUS_W = 32, PBL_W = 6, CNT_W = 16, ADDR_W = 32;
  localparam int LB = BUS_W / 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [PBL_W-1:0] pbl = '0;
  logic tx_run = 1'b0, rx_run = 1'b0, rx_eof = 1'b0;
  logic [CNT_W-1:0] tx_free = '0, tx_left = '0, rx_fill = '0;
  logic [ADDR_W-1:0] tx_addr = '0, rx_addr = '0;
  logic req_valid, req_is_rx;
  logic [ADDR_W-1:0] req_addr;
  logic [PBL_W-1:0] req_beats, desc_beats;

  always #2 clk = ~clk; // 250 MHz

  dma_burst_trigger #(.BUS_W(BUS_W), .PBL_W(PBL_W), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) i_dma_burst_trigger (
    .clk(clk), .rst_n(rst_n), .pbl(pbl), .tx_run(tx_run), .tx_free(tx_free),
    .tx_left(tx_left), .tx_addr(tx_addr), .rx_run(rx_run), .rx_fill(rx_fill),
    .rx_eof(rx_eof), .rx_addr(rx_addr), .req_valid(req_valid), .req_is_rx(req_is_rx),
    .req_addr(req_addr), .req_beats(req_beats), .desc_beats(desc_beats)
  );

  int n_checks = 0, n_fail = 0;
  string tag = "R1";
  bit checking = 1'b0;
  bit done = 1'b0;

  // Reference model: plain integers, recomputed from the requirements.
  bit m_valid, m_rx, m_last_rx;
  int m_beats;
  longint m_addr;

  always @(posedge clk) begin
    int burst, tb, rb;
    bit te, re, g_rx;
    if (!rst_n) begin
      m_valid <= 0; m_rx <= 0; m_addr <= 0; m_beats <= 0; m_last_rx <= 1;
    end else begin
      burst = int'(pbl) * LB;
      te = 0; re = 0; tb = 0; rb = 0;
      if (tx_run && burst > 0 && tx_left != 0) begin
        if (tx_left >= burst && tx_free >= burst) begin te = 1; tb = pbl; end
        else if (tx_left < burst && tx_free >= tx_left) begin te = 1; tb = (int'(tx_left) + LB - 1) / LB; end
      end
      if (rx_run && burst > 0) begin
        if (rx_fill >= burst) begin re = 1; rb = pbl; end
        else if (rx_eof && rx_fill != 0) begin re = 1; rb = (int'(rx_fill) + LB - 1) / LB; end
      end
      g_rx = re && (!te || !m_last_rx);
      m_valid <= te || re;
      m_rx <= g_rx;
      m_addr <= g_rx ? rx_addr : tx_addr;
      m_beats <= g_rx ? rb : (te ? tb : 0);
      if (te || re) m_last_rx <= g_rx;
    end
  end

  always @(posedge clk) begin
    int dexp;
    #1;
    if (checking) begin
      n_checks++;
      if (req_valid !== m_valid || (m_valid && (req_is_rx !== m_rx || req_addr !== m_addr[ADDR_W-1:0] || int'(req_beats) != m_beats))) begin
        n_fail++;
        $display("FAIL %s: got v=%0b rx=%0b addr=%h beats=%0d, expected v=%0b rx=%0b addr=%h beats=%0d",
                 tag, req_valid, req_is_rx, req_addr, req_beats, m_valid, m_rx, m_addr[ADDR_W-1:0], m_beats);
      end
      dexp = (int'(pbl) < 128 / BUS_W) ? int'(pbl) : 128 / BUS_W;
      n_checks++;
      if (int'(desc_beats) != dexp) begin
        n_fail++;
        $display("FAIL R10: desc_beats got %0d expected %0d", desc_beats, dexp);
      end
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_tx(input bit run, input int free, input int left, input int addr);
    tx_run = run; tx_free = CNT_W'(free); tx_left = CNT_W'(left); tx_addr = ADDR_W'(addr);
  endtask

  task automatic set_rx(input bit run, input int fill, input bit eof, input int addr);
    rx_run = run; rx_fill = CNT_W'(fill); rx_eof = eof; rx_addr = ADDR_W'(addr);
  endtask

  initial begin
    // R1: inputs fully eligible while in reset
    pbl = 6'd8;
    set_tx(1, 64, 100, 'h1000);
    set_rx(1, 64, 1, 'h2000);
    checking = 1;
    tag = "R1";
    step(3);
    rst_n = 1;
    step(1);
    set_tx(0, 0, 0, 0); set_rx(0, 0, 0, 0);
    step(2);
    tag = "R2"; set_tx(1, 64, 100, 'h1100); step(3);
    set_tx(1, 31, 100, 'h1104); step(2);
    set_tx(1, 32, 32, 'h1108); step(2);
    tag = "R3"; set_tx(1, 12, 10, 'h1200); step(2);
    set_tx(1, 9, 10, 'h1204); step(2);
    set_tx(1, 40, 31, 'h1208); step(2);
    set_tx(1, 40, 1, 'h120c); step(2);
    tag = "R4"; set_tx(1, 200, 0, 'h1300); step(3);
    set_tx(0, 0, 0, 0);
    tag = "R5"; set_rx(1, 40, 0, 'h2100); step(2);
    set_rx(1, 32, 0, 'h2104); step(2);
    tag = "R6"; set_rx(1, 20, 0, 'h2200); step(2);
    set_rx(1, 20, 1, 'h2204); step(2);
    set_rx(1, 0, 1, 'h2208); step(2);
    set_rx(1, 31, 1, 'h220c); step(2);
    tag = "R7"; set_rx(0, 64, 1, 'h2300); set_tx(1, 64, 64, 'h1400); step(3);
    set_rx(1, 64, 1, 'h2304); set_tx(0, 64, 64, 'h1404); step(3);
    tag = "R8"; set_tx(1, 64, 64, 'h1500); set_rx(1, 64, 0, 'h2500); step(6);
    set_rx(0, 0, 0, 0); step(1);
    set_rx(1, 64, 0, 'h2504); step(5);
    tag = "R11"; pbl = 0; step(3);
    tag = "R10"; pbl = 6'd2; step(2); pbl = 6'd4; step(2); pbl = 6'd1; step(2); pbl = 6'd63; step(2);
    tag = "R9";
    for (int i = 0; i < 400; i++) begin
      pbl = PBL_W'($urandom_range(0, 16));
      set_tx($urandom_range(0, 3) != 0, $urandom_range(0, 80), $urandom_range(0, 80), $urandom);
      set_rx($urandom_range(0, 3) != 0, $urandom_range(0, 80), $urandom_range(0, 1) == 1, $urandom);
      step(1);
    end
    step(2);
    checking = 0;
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got hung run, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule